// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the logic-level clock phases that drive a full-frame CCD through its integrate-then-read loop from one system clock. The phases are two vertical phases, two complementary horizontal phases, a separate copy of the output-side horizontal phase, and a reset-gate pulse. Analog level shifting, clock drivers and the converter are outside it. A start request opens an integration window of programmable length. During that window every phase holds its rest level. A readout follows, one line at a time.

Each line opens with a vertical transfer. The first vertical phase pulses, then the second. A programmable settle delay follows, so that the row can land in the horizontal register. The line then shifts out a fixed number of pixels, each four system cycles long. Inside every pixel the reset gate clears the sense node first. The output-side phase then falls to dump the next packet, and a pixel-valid strobe marks the slot in which the converter may sample. After the last pixel of the last line a frame-done pulse is given. The block then stops or, when continuous mode is set, starts the next integration at once.

Top module: `ccd_seq_top`

## Requirements
- R1: While reset is high, and on the first edge after it, the outputs take the rest state: v1=0, v2=0, h1=1, h1l=1, h2=0, rg=0, pix_valid=0, line_mark=0, frame_done=0, busy=0. A reset in the middle of a frame returns the block to this state, and it stays there until the next start.
- R2: Sampling start=1 while idle begins integration. The integration lasts int_len cycles. busy is 1 throughout, the verticals stay low, h1 stays high and h2, rg and pix_valid stay low.
- R3: Every line opens with v1 high for vt_len cycles. In the cycle v1 falls, v2 rises, and v2 stays high for vt_len cycles. v1 and v2 are never high together. line_mark is 1 only in the first v1 cycle of each line.
- R4: h1 is high during both vertical pulses, and it is high when v2 falls. After v2 falls, settle_len cycles pass with h1=1 and h2=0 before the first horizontal edge.
- R5: A pixel lasts four cycles, numbered slots 0 to 3. h1=1 in slots 0 and 1, and h1=0 in slots 2 and 3. h2 is always the complement of h1, and h1l always equals h1.
- R6: rg is 1 in slot 0 only, and pix_valid is 1 in slot 3 only. Each line carries exactly PIXELS pixels.
- R7: A frame reads LINES lines. frame_done is 1 for the single cycle after the last pixel of the last line, with busy still 1. When cont=0, busy is 0 in the following cycle.
- R8: When cont=1 at the end of a frame, the cycle after frame_done is already the first integration cycle of the next frame.
- R9: start has no effect while busy is 1.
- R10: A value of 0 in int_len, vt_len or settle_len counts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one pixel is four cycles |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a frame (ignored while busy) |
| cont | input | 1 | Continuous mode: loop back to integration after a frame |
| int_len | input | INT_W | Integration length in cycles |
| vt_len | input | TIME_W | Width of each vertical pulse in cycles |
| settle_len | input | TIME_W | Vertical-to-horizontal settle delay in cycles |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h1l | output | 1 | Output-side horizontal phase, follows h1 |
| rg | output | 1 | Reset-gate pulse |
| pix_valid | output | 1 | Converter sample strobe |
| line_mark | output | 1 | First cycle of each line transfer |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |

## Verification
The checker assumes that int_len, vt_len, settle_len and cont change only when the block is idle, or, for cont, before the end-of-frame cycle they govern. Under that assumption the cycle lengths of the phases are fixed for a whole frame. The stimulus only changes these inputs between frames, and it clears cont right after the first frame_done of a continuous run, well before the second frame ends. The bench pulses start while a frame is running, and it raises reset in the middle of a frame, to cover the cases where inputs arrive at inconvenient moments. Every cycle of each frame is compared with a sequence built from the requirements.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_V1,
    ST_V2,
    ST_SETTLE,
    ST_HSHIFT,
    ST_FEND
  } seq_st_e;

  localparam int SLOT_W = 2;
  localparam logic [SLOT_W-1:0] SLOT_RG   = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_H1LO = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_SMP  = 2'd3;

endpackage

// File: rtl/ccd_hpix.sv
module ccd_hpix
  import ccd_seq_pkg::*;
#(
  parameter int PIXELS = 4641
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [SLOT_W-1:0] slot,
  output logic              line_end
);
  localparam int PIX_W = $clog2(PIXELS + 1);

  logic [PIX_W-1:0] pix;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot <= '0;
      pix  <= '0;
    end else begin
      slot <= slot + 1'b1;
      if (slot == SLOT_SMP) begin
        if (pix == PIX_W'(PIXELS - 1)) pix <= '0;
        else                           pix <= pix + 1'b1;
      end
    end
  end

  assign line_end = run && (slot == SLOT_SMP) && (pix == PIX_W'(PIXELS - 1));

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int TIME_W = 16,
  parameter int LINES  = 3695
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cont,
  input  logic [INT_W-1:0]  int_len,
  input  logic [TIME_W-1:0] vt_len,
  input  logic [TIME_W-1:0] settle_len,
  input  logic              line_end,
  output seq_st_e           st,
  output logic              first_cyc
);
  localparam int LN_W = $clog2(LINES + 1);

  seq_st_e          nxt;
  logic [INT_W-1:0] cnt;
  logic [INT_W-1:0] lim;
  logic [LN_W-1:0]  line;
  logic             tdone;
  logic             last_line;

  logic [INT_W-1:0]  int_m1;
  logic [TIME_W-1:0] vt_m1;
  logic [TIME_W-1:0] st_m1;

  always_comb begin
    int_m1 = (int_len == '0)    ? '0 : int_len - 1'b1;
    vt_m1  = (vt_len == '0)     ? '0 : vt_len - 1'b1;
    st_m1  = (settle_len == '0) ? '0 : settle_len - 1'b1;
    case (st)
      ST_INTEG:     lim = int_m1;
      ST_V1, ST_V2: lim = INT_W'(vt_m1);
      ST_SETTLE:    lim = INT_W'(st_m1);
      default:      lim = '0;
    endcase
  end

  assign tdone     = (cnt >= lim);
  assign last_line = (line == LN_W'(LINES - 1));
  assign first_cyc = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:   if (start) nxt = ST_INTEG;
      ST_INTEG:  if (tdone) nxt = ST_V1;
      ST_V1:     if (tdone) nxt = ST_V2;
      ST_V2:     if (tdone) nxt = ST_SETTLE;
      ST_SETTLE: if (tdone) nxt = ST_HSHIFT;
      ST_HSHIFT: if (line_end) nxt = last_line ? ST_FEND : ST_V1;
      ST_FEND:   nxt = cont ? ST_INTEG : ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      line <= '0;
    end else begin
      st <= nxt;
      if (nxt != st || st == ST_IDLE || st == ST_HSHIFT) cnt <= '0;
      else                                               cnt <= cnt + 1'b1;
      if (nxt == ST_INTEG && st != ST_INTEG)     line <= '0;
      else if (st == ST_HSHIFT && nxt == ST_V1)  line <= line + 1'b1;
    end
  end

endmodule

// File: rtl/ccd_phase_out.sv
module ccd_phase_out
  import ccd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_st_e           st,
  input  logic [SLOT_W-1:0] slot,
  input  logic              first_cyc,
  output logic              v1,
  output logic              v2,
  output logic              h1,
  output logic              h2,
  output logic              h1l,
  output logic              rg,
  output logic              pix_valid,
  output logic              line_mark,
  output logic              frame_done,
  output logic              busy
);
  logic shifting, h_low;

  assign shifting = (st == ST_HSHIFT);
  assign h_low    = shifting && (slot >= SLOT_H1LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; h1 <= 1'b1; h2 <= 1'b0; h1l <= 1'b1;
      rg <= 1'b0; pix_valid <= 1'b0; line_mark <= 1'b0;
      frame_done <= 1'b0; busy <= 1'b0;
    end else begin
      v1         <= (st == ST_V1);
      v2         <= (st == ST_V2);
      h1         <= !h_low;
      h1l        <= !h_low;
      h2         <= h_low;
      rg         <= shifting && (slot == SLOT_RG);
      pix_valid  <= shifting && (slot == SLOT_SMP);
      line_mark  <= (st == ST_V1) && first_cyc;
      frame_done <= (st == ST_FEND);
      busy       <= (st != ST_IDLE);
    end
  end

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int TIME_W = 16,
  parameter int PIXELS = 4641,
  parameter int LINES  = 3695
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cont,
  input  logic [INT_W-1:0]  int_len,
  input  logic [TIME_W-1:0] vt_len,
  input  logic [TIME_W-1:0] settle_len,
  output logic              v1,
  output logic              v2,
  output logic              h1,
  output logic              h2,
  output logic              h1l,
  output logic              rg,
  output logic              pix_valid,
  output logic              line_mark,
  output logic              frame_done,
  output logic              busy
);
  seq_st_e           st;
  logic              first_cyc;
  logic              line_end;
  logic [SLOT_W-1:0] slot;

  ccd_seq_ctrl #(.INT_W(INT_W), .TIME_W(TIME_W), .LINES(LINES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cont(cont),
    .int_len(int_len), .vt_len(vt_len), .settle_len(settle_len),
    .line_end(line_end), .st(st), .first_cyc(first_cyc)
  );

  ccd_hpix #(.PIXELS(PIXELS)) u_hpix (
    .clk(clk), .rst(rst), .run(st == ST_HSHIFT),
    .slot(slot), .line_end(line_end)
  );

  ccd_phase_out u_out (
    .clk(clk), .rst(rst), .st(st), .slot(slot), .first_cyc(first_cyc),
    .v1(v1), .v2(v2), .h1(h1), .h2(h2), .h1l(h1l), .rg(rg),
    .pix_valid(pix_valid), .line_mark(line_mark),
    .frame_done(frame_done), .busy(busy)
  );

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic v1,
  input logic v2,
  input logic h1,
  input logic h2,
  input logic h1l,
  input logic rg,
  input logic pix_valid,
  input logic line_mark,
  input logic frame_done,
  input logic busy
);
  // R1
  rest_after_rst_chk: assert property (@(posedge clk)
    rst |=> (!v1 && !v2 && h1 && h1l && !h2 && !rg && !pix_valid && !busy && !frame_done));

  // R3
  v_excl_chk: assert property (@(posedge clk) disable iff (rst) !(v1 && v2));

  // R3
  v2_follows_v1_chk: assert property (@(posedge clk) disable iff (rst) $fell(v1) |-> v2);

  // R3
  mark_in_v1_chk: assert property (@(posedge clk) disable iff (rst) line_mark |-> v1);

  // R4
  h1_hold_v_chk: assert property (@(posedge clk) disable iff (rst) (v1 || v2) |-> (h1 && !h2));

  // R4
  v2_fall_h1_chk: assert property (@(posedge clk) disable iff (rst) $fell(v2) |-> (h1 && !h2));

  // R5
  h_comp_chk: assert property (@(posedge clk) disable iff (rst) h1 != h2);

  // R5
  h1l_follow_chk: assert property (@(posedge clk) disable iff (rst) h1l == h1);

  // R6
  rg_slot_chk: assert property (@(posedge clk) disable iff (rst) rg |-> (h1 && !pix_valid && busy));

  // R6
  smp_slot_chk: assert property (@(posedge clk) disable iff (rst) pix_valid |-> (h2 && !rg));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) frame_done |=> !frame_done);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (rst) frame_done |-> busy);

endmodule

bind ccd_seq_top ccd_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .v1(v1), .v2(v2), .h1(h1), .h2(h2),
  .h1l(h1l), .rg(rg), .pix_valid(pix_valid), .line_mark(line_mark),
  .frame_done(frame_done), .busy(busy)
);

// File: tb/sim_ccd_seq_top.sv
`timescale 1ns/1ps
module sim_ccd_seq_top;
  localparam int INT_W  = 12;
  localparam int TIME_W = 8;
  localparam int PIXELS = 5;
  localparam int LINES  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cont = 1'b0;
  logic [INT_W-1:0]  int_len = '0;
  logic [TIME_W-1:0] vt_len = '0;
  logic [TIME_W-1:0] settle_len = '0;
  logic v1, v2, h1, h2, h1l, rg, pix_valid, line_mark, frame_done, busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ccd_seq_top #(.INT_W(INT_W), .TIME_W(TIME_W), .PIXELS(PIXELS), .LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .start(start), .cont(cont), .int_len(int_len),
    .vt_len(vt_len), .settle_len(settle_len), .v1(v1), .v2(v2), .h1(h1),
    .h2(h2), .h1l(h1l), .rg(rg), .pix_valid(pix_valid), .line_mark(line_mark),
    .frame_done(frame_done), .busy(busy)
  );

  // observed vector: {busy,v1,v2,h1,h2,h1l,rg,pix_valid,line_mark,frame_done}
  function automatic logic [9:0] mk(input logic b, input logic a1, input logic a2,
                                     input logic g1, input logic g2, input logic r,
                                     input logic p, input logic lm, input logic fd);
    return {b, a1, a2, g1, g2, g1, r, p, lm, fd};
  endfunction

  wire [9:0] obs = {busy, v1, v2, h1, h2, h1l, rg, pix_valid, line_mark, frame_done};
  localparam logic [9:0] IDLE_V = 10'b0001010000;

  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       active = 1'b0;
  int         skip = 0;

  task automatic push(input logic [9:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic check(input logic [9:0] got, input logic [9:0] exp, input string t);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", t, got, exp, $time);
    end
  endtask

  // expected sequence of one frame, built from the requirements
  task automatic push_frame(input int il, input int tv, input int sl, input string itag,
                            input string ztag);
    int ie = (il == 0) ? 1 : il;
    int te = (tv == 0) ? 1 : tv;
    int se = (sl == 0) ? 1 : sl;
    for (int i = 0; i < ie; i++) push(mk(1,0,0,1,0,0,0,0,0), (ztag != "") ? ztag : itag);
    for (int ln = 0; ln < LINES; ln++) begin
      for (int i = 0; i < te; i++) push(mk(1,1,0,1,0,0,0,(i == 0),0), (ztag != "") ? ztag : "R3");
      for (int i = 0; i < te; i++) push(mk(1,0,1,1,0,0,0,0,0), (ztag != "") ? ztag : "R3");
      for (int i = 0; i < se; i++) push(mk(1,0,0,1,0,0,0,0,0), (ztag != "") ? ztag : "R4");
      for (int p = 0; p < PIXELS; p++) begin
        push(mk(1,0,0,1,0,1,0,0,0), "R6 rg slot");
        push(mk(1,0,0,1,0,0,0,0,0), "R5 slot1");
        push(mk(1,0,0,0,1,0,0,0,0), "R5 slot2");
        push(mk(1,0,0,0,1,0,1,0,0), "R6 sample slot");
      end
    end
    push(mk(1,0,0,1,0,0,0,0,1), "R7 frame_done");
  endtask

  // monitor: compares one expected item per cycle once a start is seen
  always @(negedge clk) begin
    if (!active) begin
      if (start && exp_q.size() > 0) begin
        active = 1'b1;
        skip = 1;
      end
    end else if (skip > 0) begin
      skip--;
    end else if (exp_q.size() > 0) begin
      check(obs, exp_q.pop_front(), tag_q.pop_front());
      if (exp_q.size() == 0) active = 1'b0;
    end
  end

  task automatic kick();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done();
    @(posedge clk);
    while (active) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(obs, IDLE_V, "R1 reset state");

    // plain frame
    int_len = 3; vt_len = 2; settle_len = 3;
    push_frame(3, 2, 3, "R2", "");
    for (int i = 0; i < 3; i++) push(IDLE_V, "R7 idle after frame");
    kick();
    wait_done();

    // all counts zero
    int_len = 0; vt_len = 0; settle_len = 0;
    push_frame(0, 0, 0, "R2", "R10");
    push(IDLE_V, "R10 idle after");
    kick();
    wait_done();

    // longer timing, start pulsed mid-frame
    int_len = 5; vt_len = 3; settle_len = 4;
    push_frame(5, 3, 4, "R2", "");
    for (int i = 0; i < 2; i++) push(IDLE_V, "R9 no restart");
    kick();
    repeat (30) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();

    // continuous mode: two frames back to back
    int_len = 2; vt_len = 1; settle_len = 2; cont = 1'b1;
    push_frame(2, 1, 2, "R2", "");
    push_frame(2, 1, 2, "R8 next integration", "");
    for (int i = 0; i < 2; i++) push(IDLE_V, "R8 stop after cont cleared");
    kick();
    while (!frame_done) @(posedge clk);
    #1 cont = 1'b0;
    wait_done();

    // reset in the middle of a frame
    int_len = 2; vt_len = 2; settle_len = 2;
    kick();
    repeat (25) @(posedge clk);
    @(negedge clk);
    checks++;
    if (busy !== 1'b1) begin
      errors++;
      $display("FAIL R2 busy mid-frame: got %b expected 1", busy);
    end
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(obs, IDLE_V, "R1 after mid-frame reset");
    repeat (4) @(negedge clk);
    check(obs, IDLE_V, "R1 stays idle after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule